// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Interrupt Routing

This block gathers a parameterized number of interrupt sources, arranged as 32-bit banks, and reports them to a processor on two lines. One is a normal interrupt request and the other is a fast interrupt. Each bank has three registers. The pending register latches a source that is seen high. The mask register blocks a source from both outputs. The select register routes an unmasked pending source to the fast line as well.

A read-only vector word gives the handler the byte offset of the lowest-numbered source that is both pending and unmasked. There is no priority scheme, so a handler can use the vector directly as an index into a table of 4-byte entries.

Software reaches every register through a small word-aligned bus with a write enable and a combinational read-data output. The bus also reaches a base-address word and a protection flag, which are plain storage for software. The two outputs and the vector depend only on the registered state. Any write or source capture therefore shows on them in the cycle after the clock edge that stored it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every pending, mask and select bit, the base word and the protection flag are zero, irq_o and fiq_o are low, and vector_o reads 0.
- R2: irq_o is high exactly when some source across all banks has its pending bit set and its mask bit clear.
- R3: fiq_o is high exactly when some source has its pending bit set, its mask bit clear and its select bit set.
- R4: vector_o is four times the global index (bank*32 + bit) of the lowest-numbered pending unmasked source. Lower banks are searched first, and within a bank the lowest bit wins. When no source qualifies, vector_o is 0. The vector can also be read at address 0x00.
- R5: A write to the vector address 0x00 changes nothing, and the vector keeps showing the computed value.
- R6: The base word at address 0x04 stores the written data with bits [1:0] forced to zero.
- R7: An access counts only when addr[7:6]=0 and addr[1:0]=0. addr[5:4] picks the region: 0 for control, 1 for pending, 2 for mask and 3 for select. addr[3:2] picks the bank. A bank index of NUM_BANKS or more, control slot 3 (0x0C), or a bad address is ignored on write and reads 0.
- R8: A pending bit is set at any clock edge where its source input is high and stays set until it is cleared. Writing 1 to a pending bit clears it and writing 0 leaves it alone. A source that is high in the same cycle as a clearing write keeps its bit set.
- R9: Mask and select words are plain read/write storage. The protection flag at address 0x08 keeps only bit 0, and its other bits read 0.
- R10: irq_o, fiq_o and vector_o reflect a register write or a source capture in the cycle right after the clock edge that stored it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | NUM_BANKS*32 | Interrupt source lines, bit b*32+i is source i of bank b |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vector_o | output | 32 | Byte offset of the lowest pending unmasked source |

## Verification
Random sparse source patterns are mixed with random mask, select and clearing writes. These separate a lowest-index search from a highest-index search, and they show whether the search order across banks is right. Directed cases cover three points:
- the top source (index 95) alone, which shows that the bank index is scaled into the vector;
- source 0 pending, which shows a vector of 0 with irq_o high;
- a full-bank mask, which shows both outputs dropping in the cycle after the write.

Further directed cases cover writes to the vector, the base word, a missing bank and an unaligned address. These show that an ignored access leaves every readable register unchanged.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int BANK_W  = 32;
  localparam int LOW_W   = $clog2(BANK_W);
  localparam int BSEL_W  = 2;

  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_PEND = 2'd1;
  localparam logic [1:0] RG_MASK = 2'd2;
  localparam logic [1:0] RG_SEL  = 2'd3;

  localparam logic [1:0] SLOT_VEC  = 2'd0;
  localparam logic [1:0] SLOT_BASE = 2'd1;
  localparam logic [1:0] SLOT_PROT = 2'd2;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BUS_W-1:0]            wdata,
  output logic [NUM_BANKS*BANK_W-1:0] pend_q,
  output logic [NUM_BANKS*BANK_W-1:0] mask_q,
  output logic [NUM_BANKS*BANK_W-1:0] sel_q,
  output logic [BUS_W-1:0]            base_q,
  output logic                        prot_q
);
  localparam int NSRC = NUM_BANKS * BANK_W;

  logic            acc_ok;
  logic [1:0]      region;
  logic [1:0]      bank;
  logic [NSRC-1:0] pend_d, mask_d, sel_d;
  logic [BUS_W-1:0] base_d;
  logic            prot_d;
  logic            cfg_en;

  assign acc_ok = wr_en && (addr[7:6] == 2'b00) && (addr[1:0] == 2'b00);
  assign region = addr[5:4];
  assign bank   = addr[3:2];
  assign cfg_en = acc_ok;

  always_comb begin
    pend_d = pend_q | src;
    mask_d = mask_q;
    sel_d  = sel_q;
    base_d = base_q;
    prot_d = prot_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (acc_ok && bank == 2'(b)) begin
        case (region)
          RG_PEND: pend_d[b*BANK_W +: BANK_W] =
                     (pend_q[b*BANK_W +: BANK_W] & ~wdata) | src[b*BANK_W +: BANK_W];
          RG_MASK: mask_d[b*BANK_W +: BANK_W] = wdata;
          RG_SEL:  sel_d[b*BANK_W +: BANK_W]  = wdata;
          default: ;
        endcase
      end
    end
    if (acc_ok && region == RG_CTRL && bank == SLOT_BASE)
      base_d = {wdata[BUS_W-1:2], 2'b00};
    if (acc_ok && region == RG_CTRL && bank == SLOT_PROT)
      prot_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      sel_q  <= '0;
      base_q <= '0;
      prot_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (cfg_en) begin
        mask_q <= mask_d;
        sel_q  <= sel_d;
        base_q <= base_d;
        prot_q <= prot_d;
      end
    end
  end
endmodule

// File: rtl/irqv_scan.sv
module irqv_scan
  import irqv_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [NUM_BANKS*BANK_W-1:0] pend,
  input  logic [NUM_BANKS*BANK_W-1:0] mask,
  input  logic [NUM_BANKS*BANK_W-1:0] sel,
  output logic                        irq,
  output logic                        fiq,
  output logic [BUS_W-1:0]            vec
);
  localparam int NSRC = NUM_BANKS * BANK_W;
  localparam int PAD  = BUS_W - BSEL_W - LOW_W - 2;

  logic [NSRC-1:0]            live;
  logic [NUM_BANKS-1:0]       bank_any;
  logic [NUM_BANKS*LOW_W-1:0] low_flat;
  logic                       found;
  logic [BSEL_W-1:0]          win_bank;
  logic [LOW_W-1:0]           win_low;

  assign live = pend & ~mask;
  assign irq  = |live;
  assign fiq  = |(live & sel);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LOW_W-1:0] low;
    assign bank_any[b] = |live[b*BANK_W +: BANK_W];
    always_comb begin
      low = '0;
      for (int i = BANK_W - 1; i >= 0; i--) begin
        if (live[b*BANK_W + i]) low = LOW_W'(i);
      end
    end
    assign low_flat[b*LOW_W +: LOW_W] = low;
  end

  always_comb begin
    found    = 1'b0;
    win_bank = '0;
    win_low  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!found && bank_any[b]) begin
        found    = 1'b1;
        win_bank = BSEL_W'(b);
        win_low  = low_flat[b*LOW_W +: LOW_W];
      end
    end
  end

  assign vec = found ? {{PAD{1'b0}}, win_bank, win_low, 2'b00} : '0;
endmodule

// File: rtl/irqv_rdmux.sv
module irqv_rdmux
  import irqv_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BANKS*BANK_W-1:0] pend,
  input  logic [NUM_BANKS*BANK_W-1:0] mask,
  input  logic [NUM_BANKS*BANK_W-1:0] sel,
  input  logic [BUS_W-1:0]            vec,
  input  logic [BUS_W-1:0]            base,
  input  logic                        prot,
  output logic [BUS_W-1:0]            rdata
);
  logic       ok;
  logic [1:0] region;
  logic [1:0] bank;

  assign ok     = (addr[7:6] == 2'b00) && (addr[1:0] == 2'b00);
  assign region = addr[5:4];
  assign bank   = addr[3:2];

  always_comb begin
    rdata = '0;
    if (ok) begin
      if (region == RG_CTRL) begin
        case (bank)
          SLOT_VEC:  rdata = vec;
          SLOT_BASE: rdata = base;
          SLOT_PROT: rdata = {{(BUS_W-1){1'b0}}, prot};
          default:   rdata = '0;
        endcase
      end else begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bank == 2'(b)) begin
            case (region)
              RG_PEND: rdata = pend[b*BANK_W +: BANK_W];
              RG_MASK: rdata = mask[b*BANK_W +: BANK_W];
              default: rdata = sel[b*BANK_W +: BANK_W];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BUS_W-1:0]            bus_wdata,
  output logic [BUS_W-1:0]            bus_rdata,
  output logic                        irq_o,
  output logic                        fiq_o,
  output logic [BUS_W-1:0]            vector_o
);
  localparam int NSRC = NUM_BANKS * BANK_W;

  logic            rst_meta;
  logic            srst_n;
  logic [NSRC-1:0] pend_q, mask_q, sel_q;
  logic [BUS_W-1:0] base_q;
  logic            prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  irqv_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk    (clk),
    .rst_n  (srst_n),
    .src    (src_i),
    .wr_en  (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .pend_q (pend_q),
    .mask_q (mask_q),
    .sel_q  (sel_q),
    .base_q (base_q),
    .prot_q (prot_q)
  );

  irqv_scan #(.NUM_BANKS(NUM_BANKS)) u_scan (
    .pend (pend_q),
    .mask (mask_q),
    .sel  (sel_q),
    .irq  (irq_o),
    .fiq  (fiq_o),
    .vec  (vector_o)
  );

  irqv_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rdmux (
    .addr  (bus_addr),
    .pend  (pend_q),
    .mask  (mask_q),
    .sel   (sel_q),
    .vec   (vector_o),
    .base  (base_q),
    .prot  (prot_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input logic                        clk,
  input logic                        srst_n,
  input logic [NUM_BANKS*BANK_W-1:0] src_i,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BUS_W-1:0]            bus_rdata,
  input logic                        irq_o,
  input logic                        fiq_o,
  input logic [BUS_W-1:0]            vector_o,
  input logic [NUM_BANKS*BANK_W-1:0] pend_q,
  input logic [NUM_BANKS*BANK_W-1:0] mask_q
);
  // R3: the fast line never rises without the normal line
  p_fiq_needs_irq_r3: assert property (@(posedge clk) disable iff (!srst_n)
    fiq_o |-> irq_o);

  // R4: a non-zero vector means a qualifying source exists
  p_vec_needs_irq_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (vector_o != '0) |-> irq_o);

  // R4: vector is a multiple of four
  p_vec_aligned_r4: assert property (@(posedge clk) disable iff (!srst_n)
    vector_o[1:0] == 2'b00);

  // R6: base word never shows low bits
  p_base_aligned_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr == 8'h04) |-> (bus_rdata[1:0] == 2'b00));

  // R8: a high source is captured at the edge
  p_pend_capture_r8: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((pend_q & $past(src_i)) == $past(src_i)));

  // R8: pending holds without sources or writes
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!bus_we && src_i == '0) |=> $stable(pend_q));

  // R9: mask changes only through a write
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_we |=> $stable(mask_q));
endmodule

bind irq_vector_ctrl irqv_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .src_i     (src_i),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .vector_o  (vector_o),
  .pend_q    (pend_q),
  .mask_q    (mask_q)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  localparam int NB   = 3;
  localparam int NSRC = NB * 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_i;
  logic [7:0]      bus_addr;
  logic            bus_we;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq_o, fiq_o;
  logic [31:0]     vector_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_pend [NB];
  logic [31:0] m_mask [NB];
  logic [31:0] m_sel  [NB];
  logic [31:0] m_base;
  logic        m_prot;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_BANKS(NB)) u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .vector_o(vector_o)
  );

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(m_pend[b] & ~m_mask[b]);
    return r;
  endfunction

  function automatic logic exp_fiq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(m_pend[b] & ~m_mask[b] & m_sel[b]);
    return r;
  endfunction

  function automatic logic [31:0] exp_vec();
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i/32][i%32] && !m_mask[i/32][i%32]) return 32'(i * 4);
    return 32'd0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int bk = int'(a[3:2]);
    if (a[7:6] != 2'b00 || a[1:0] != 2'b00) return 32'd0;
    case (a[5:4])
      2'd0: case (a[3:2])
              2'd0: return exp_vec();
              2'd1: return m_base;
              2'd2: return {31'd0, m_prot};
              default: return 32'd0;
            endcase
      2'd1: return (bk < NB) ? m_pend[bk] : 32'd0;
      2'd2: return (bk < NB) ? m_mask[bk] : 32'd0;
      default: return (bk < NB) ? m_sel[bk] : 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "irq_o", {31'd0, irq_o}, {31'd0, exp_irq()});
    chk("R3", "fiq_o", {31'd0, fiq_o}, {31'd0, exp_fiq()});
    chk("R4", "vector_o", vector_o, exp_vec());
    chk("R7", "bus_rdata", bus_rdata, exp_read(bus_addr));
  endtask

  task automatic model_update(input logic [NSRC-1:0] s, input logic we,
                              input logic [7:0] a, input logic [31:0] d);
    logic ok = we && a[7:6] == 2'b00 && a[1:0] == 2'b00;
    int bk = int'(a[3:2]);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] clr = (ok && a[5:4] == 2'd1 && bk == b) ? d : 32'd0;
      m_pend[b] = (m_pend[b] & ~clr) | s[b*32 +: 32];
    end
    if (ok && bk < NB && a[5:4] == 2'd2) m_mask[bk] = d;
    if (ok && bk < NB && a[5:4] == 2'd3) m_sel[bk]  = d;
    if (ok && a[5:2] == 4'd1) m_base = {d[31:2], 2'b00};
    if (ok && a[5:2] == 4'd2) m_prot = d[0];
  endtask

  // Drives inputs at a falling edge, updates the model at the rising edge,
  // compares at the next falling edge.
  task automatic cyc(input logic [NSRC-1:0] s, input logic we,
                     input logic [7:0] a, input logic [31:0] d);
    src_i = s; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_update(s, we, a, d);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] s;
    void'($urandom(32'd20240317));
    for (int b = 0; b < NB; b++) begin
      m_pend[b] = '0; m_mask[b] = '0; m_sel[b] = '0;
    end
    m_base = '0; m_prot = 1'b0;
    rst_n = 1'b0; src_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values of every register and both outputs
    for (int a = 0; a < 64; a += 4) begin
      cyc('0, 1'b0, 8'(a), 32'd0);
      chk("R1", "reset read", bus_rdata, 32'd0);
    end
    chk("R1", "reset irq", {31'd0, irq_o}, 32'd0);
    chk("R1", "reset vector", vector_o, 32'd0);

    // R4: only the top source pending
    s = '0; s[NSRC-1] = 1'b1;
    cyc(s, 1'b0, 8'h00, 32'd0);
    chk("R4", "top source vector", vector_o, 32'd380);

    // R5: write to the vector is ignored
    cyc('0, 1'b1, 8'h00, 32'hFFFF_FFF0);
    chk("R5", "vector after write", bus_rdata, 32'd380);

    // R6: base drops low bits
    cyc('0, 1'b1, 8'h04, 32'hFFFF_FFFF);
    chk("R6", "base readback", bus_rdata, 32'hFFFF_FFFC);

    // R9: protection keeps only bit 0
    cyc('0, 1'b1, 8'h08, 32'hFFFF_FFFF);
    chk("R9", "protect readback", bus_rdata, 32'd1);

    // R8: source high while its bit is cleared keeps it set
    s = '0; s[0] = 1'b1;
    cyc(s, 1'b1, 8'h10, 32'h0000_0001);
    chk("R8", "set beats clear", bus_rdata, 32'd1);
    chk("R4", "source 0 vector", vector_o, 32'd0);
    chk("R2", "source 0 irq", {31'd0, irq_o}, 32'd1);
    cyc('0, 1'b1, 8'h10, 32'h0000_0001);
    chk("R8", "write-1 clear", bus_rdata, 32'd0);
    chk("R4", "vector back to top source", vector_o, 32'd380);

    // R3: routing the top source to the fast line
    cyc('0, 1'b1, 8'h38, 32'h8000_0000);
    chk("R3", "fiq routed", {31'd0, fiq_o}, 32'd1);

    // R10: masking bank 2 drops both lines in the next cycle
    cyc('0, 1'b1, 8'h28, 32'hFFFF_FFFF);
    chk("R10", "irq after mask", {31'd0, irq_o}, 32'd0);
    chk("R10", "fiq after mask", {31'd0, fiq_o}, 32'd0);

    // R9: mask readback
    cyc('0, 1'b1, 8'h24, 32'hA5A5_5A5A);
    chk("R9", "mask readback", bus_rdata, 32'hA5A5_5A5A);

    // R7: missing bank and unaligned address are ignored
    cyc('0, 1'b1, 8'h2C, 32'h1234_5678);
    chk("R7", "bank 3 reads zero", bus_rdata, 32'd0);
    cyc('0, 1'b1, 8'h25, 32'h0000_0000);
    cyc('0, 1'b0, 8'h24, 32'd0);
    chk("R7", "unaligned write ignored", bus_rdata, 32'hA5A5_5A5A);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [NSRC-1:0] rs;
      logic [7:0]      ra;
      logic [31:0]     rd;
      for (int b = 0; b < NB; b++)
        rs[b*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      if ($urandom % 2) rs = '0;
      ra = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 16) * 4);
      rd = $urandom;
      if (ra[5:4] == 2'd2) rd = rd & $urandom;
      cyc(rs, 1'($urandom % 2), ra, rd);
    end
    cyc('0, 1'b0, 8'h00, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule